// File: doc/BRIEF.md
# Power Rail Sequencing Controller

This controller brings up a board's supply rails in a fixed order from a single power-hold level. It runs from a 32 kHz reference clock. When the hold level is recognised high, it enables six rail groups one after another, then starts a gated copy of the reference clock on its clock output, and finally releases an active-low power-on reset. The first step waits 66 reference periods. Every later step waits 64, so the whole bring-up takes about 16 ms.

When the hold level is recognised low, the controller does not retrace the bring-up order. It runs a short fixed shutdown instead. Reset is asserted first, then the clock output is stopped and every rail group is switched off in the same cycle. A fall of the hold level during bring-up cuts the bring-up short. A rise during shutdown is not acted on until the controller is fully off.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While `rst` is high, and afterwards for as long as `hold_in` stays low, `rail_en` is all zero, `rst_n_out` is low and `clk_out` stays low.
- R2: A change on `hold_in` takes effect at the third rising clock edge after the change. Edge 1 is the first rising edge that samples the new level, and edge 3 is the edge at which the controller acts on it. All edge numbers below count from edge 1.
- R3: After `hold_in` rises with the controller off, `rail_en[0]` (group A, which feeds two rails) goes high at edge 69, which is 66 periods after edge 3.
- R4: Bit g of `rail_en` is group g, in the order A, B, C, D, E (two rails), F for g = 0 to 5. Group g turns on at edge 69 + 64·g and then stays on while the hold level stays high.
- R5: `clk_out` is low until bring-up reaches the clock step at edge 453. It shows the reference clock's high phase from the high phase after edge 454 onward.
- R6: `rst_n_out` stays low throughout bring-up and goes high at edge 517.
- R7: When `hold_in` falls while the controller is fully on, `rst_n_out` goes low at edge 5.
- R8: After that fall, every bit of `rail_en` drops at edge 8. `clk_out` shows its last high phase after edge 8 and is low from edge 9 on.
- R9: A fall of `hold_in` during bring-up stops all further enables. The groups already on stay on until edge 8 of the fall and then all drop together. `rst_n_out` and `clk_out` stay low throughout.
- R10: If `hold_in` rises again during shutdown, the controller ignores it until it is fully off at edge 8. If the level is still high then, a new bring-up runs as though the controller had acted at edge 9. Group A then turns on at edge 75, and later groups follow 64 edges apart.
- R11: The rail enables always form a thermometer code: a group is never on while a lower-numbered group is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32 kHz reference clock |
| rst | input | 1 | Synchronous active-high master reset |
| hold_in | input | 1 | Power-hold level, asynchronous to `clk` |
| rail_en | output | N_GRP (6) | One enable per rail group, bit 0 first in the bring-up order |
| clk_out | output | 1 | Reference clock gated by the sequenced clock enable |
| rst_n_out | output | 1 | Active-low power-on reset |

## Verification
The hardest case to reach is a hold rise that arrives in the middle of shutdown, after reset has gone low but before the rails drop. The controller must neither restart early nor lose the request. The stimulus first completes a full bring-up. It then lowers the hold level and raises it again three edges later, so that the new level reaches the controller while it is still counting out the shutdown. The bench then checks that the rails drop on schedule and that the restart timing is measured from the fully-off cycle. A separate scenario lowers the hold level after the third rail group comes on, to check that a partial bring-up is cut short.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_UP     = 3'd1,
    ST_ON     = 3'd2,
    ST_DN_RST = 3'd3,
    ST_DN_CUT = 3'd4
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rail_seq_sync.sv
module rail_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
  import rail_seq_pkg::*;
#(
  parameter int N_GRP     = 6,
  parameter int FIRST_DLY = 66,
  parameter int STEP_DLY  = 64,
  parameter int RST_DLY   = 2,
  parameter int RAIL_DLY  = 5,
  parameter int CW        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_s,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CW-1:0]    tmr_val,
  output logic [N_GRP-1:0] rail_en,
  output logic             clk_en,
  output logic             rst_n
);

  localparam int N_STEPS = N_GRP + 2;
  localparam int SW      = $clog2(N_STEPS);
  localparam int CUT_DLY = RAIL_DLY - RST_DLY;
  localparam logic [SW-1:0] STEP_CLK = SW'(N_GRP);
  localparam logic [SW-1:0] STEP_RST = SW'(N_GRP + 1);

  seq_state_t       st, st_n;
  logic [SW-1:0]    step, step_n;
  logic [N_GRP-1:0] rail_n;
  logic             cken_n, rstn_n;

  always_comb begin
    st_n     = st;
    step_n   = step;
    rail_n   = rail_en;
    cken_n   = clk_en;
    rstn_n   = rst_n;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_OFF: begin
        if (hold_s) begin
          st_n     = ST_UP;
          step_n   = '0;
          tmr_load = 1'b1;
          tmr_val  = CW'(FIRST_DLY - 1);
        end
      end
      ST_UP: begin
        if (!hold_s) begin
          st_n     = ST_DN_RST;
          tmr_load = 1'b1;
          tmr_val  = CW'(RST_DLY - 1);
        end else if (tmr_zero) begin
          for (int g = 0; g < N_GRP; g++) begin
            if (step == SW'(g)) rail_n[g] = 1'b1;
          end
          if (step == STEP_CLK) cken_n = 1'b1;
          if (step == STEP_RST) begin
            rstn_n = 1'b1;
            st_n   = ST_ON;
          end else begin
            step_n   = step + SW'(1);
            tmr_load = 1'b1;
            tmr_val  = CW'(STEP_DLY - 1);
          end
        end
      end
      ST_ON: begin
        if (!hold_s) begin
          st_n     = ST_DN_RST;
          tmr_load = 1'b1;
          tmr_val  = CW'(RST_DLY - 1);
        end
      end
      ST_DN_RST: begin
        if (tmr_zero) begin
          rstn_n   = 1'b0;
          st_n     = ST_DN_CUT;
          tmr_load = 1'b1;
          tmr_val  = CW'(CUT_DLY - 1);
        end
      end
      ST_DN_CUT: begin
        if (tmr_zero) begin
          rail_n = '0;
          cken_n = 1'b0;
          st_n   = ST_OFF;
        end
      end
      default: st_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_OFF;
      step    <= '0;
      rail_en <= '0;
      clk_en  <= 1'b0;
      rst_n   <= 1'b0;
    end else begin
      st      <= st_n;
      step    <= step_n;
      rail_en <= rail_n;
      clk_en  <= cken_n;
      rst_n   <= rstn_n;
    end
  end

endmodule

// File: rtl/rail_seq_clkgate.sv
module rail_seq_clkgate (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic clk_gated
);

  logic en_lo;

  always_ff @(negedge clk) begin
    if (rst) en_lo <= 1'b0;
    else     en_lo <= en;
  end

  assign clk_gated = clk & en_lo;

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int N_GRP     = 6,
  parameter int SYNC_FF   = 2,
  parameter int FIRST_DLY = 66,
  parameter int STEP_DLY  = 64,
  parameter int RST_DLY   = 2,
  parameter int RAIL_DLY  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_in,
  output logic [N_GRP-1:0] rail_en,
  output logic             clk_out,
  output logic             rst_n_out
);

  localparam int MAX_DLY = max2(max2(FIRST_DLY, STEP_DLY), RAIL_DLY);
  localparam int CW      = $clog2(MAX_DLY) + 1;

  logic          hold_s;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          clk_en_q;

  rail_seq_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (hold_in),
    .q_sync  (hold_s)
  );

  rail_seq_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  rail_seq_fsm #(
    .N_GRP     (N_GRP),
    .FIRST_DLY (FIRST_DLY),
    .STEP_DLY  (STEP_DLY),
    .RST_DLY   (RST_DLY),
    .RAIL_DLY  (RAIL_DLY),
    .CW        (CW)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .hold_s   (hold_s),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .rail_en  (rail_en),
    .clk_en   (clk_en_q),
    .rst_n    (rst_n_out)
  );

  rail_seq_clkgate u_cg (
    .clk       (clk),
    .rst       (rst),
    .en        (clk_en_q),
    .clk_gated (clk_out)
  );

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int N_GRP = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [N_GRP-1:0] rail_en,
  input logic             rst_n_out,
  input logic             clk_en
);

  logic [N_GRP:0] rail_inc;
  assign rail_inc = {1'b0, rail_en} + (N_GRP+1)'(1);

  // R11: enables always form a thermometer code
  a_r11_thermometer: assert property (@(posedge clk) disable iff (rst)
    (rail_inc[N_GRP-1:0] & rail_en) == '0);

  // R4: bring-up adds at most one group per cycle
  a_r4_one_group_per_step: assert property (@(posedge clk) disable iff (rst)
    $countones(rail_en) <= $countones($past(rail_en)) + 1);

  // R8, R9: any group that goes off takes all groups off with it
  a_r8_drop_to_zero: assert property (@(posedge clk) disable iff (rst)
    (($past(rail_en) & ~rail_en) != '0) |-> (rail_en == '0));

  // R6: reset is released only with every rail and the clock running
  a_r6_release_needs_all: assert property (@(posedge clk) disable iff (rst)
    rst_n_out |-> ((&rail_en) && clk_en));

  // R7: the clock stops only after reset is already low
  a_r7_reset_before_clock_stop: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en) |-> !rst_n_out);

  // R5: the clock is only enabled with every rail on
  a_r5_clock_needs_rails: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> (&rail_en));

endmodule

bind rail_seq_ctrl rail_seq_chk #(.N_GRP(N_GRP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rail_en   (rail_en),
  .rst_n_out (rst_n_out),
  .clk_en    (clk_en_q)
);

// File: tb/tb_rail_seq_ctrl.sv
`timescale 1ns/1ps
module tb_rail_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold_in = 1'b0;
  logic [5:0] rail_en;
  logic       clk_out;
  logic       rst_n_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rail_seq_ctrl dut (
    .clk       (clk),
    .rst       (rst),
    .hold_in   (hold_in),
    .rail_en   (rail_en),
    .clk_out   (clk_out),
    .rst_n_out (rst_n_out)
  );

  task automatic chk(input string tag, input int e, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s edge %0d: actual %0h expected %0h", tag, e, act, exp);
    end
  endtask

  // advance one rising edge and sample inside the high phase
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // change hold between edges: the next rising edge is edge 1
  task automatic set_hold(input logic v);
    @(negedge clk);
    hold_in = v;
  endtask

  function automatic logic [5:0] rails_from(input int e, input int base);
    logic [5:0] r = '0;
    for (int g = 0; g < 6; g++) if (e >= base + 64*g) r[g] = 1'b1;
    return r;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    hold_in = 1'b0;
    repeat (4) tick();
    chk("R1 rails in reset", 0, rail_en, 6'h00);
    chk("R1 rst_n in reset", 0, rst_n_out, 1'b0);
    chk("R1 clk_out in reset", 0, clk_out, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    for (int e = 1; e <= 100; e++) begin
      tick();
      if (e % 25 == 0) begin
        chk("R1 rails idle", e, rail_en, 6'h00);
        chk("R1 rst_n idle", e, rst_n_out, 1'b0);
        chk("R1 clk_out idle", e, clk_out, 1'b0);
      end
    end
  endtask

  task automatic t_powerup();
    set_hold(1'b1);
    for (int e = 1; e <= 540; e++) begin
      tick();
      if (e < 69)       chk("R2 no early enable", e, rail_en, 6'h00);
      else if (e == 69) chk("R3 group A", e, rail_en, rails_from(e, 69));
      else              chk("R4 rail order", e, rail_en, rails_from(e, 69));
      chk("R5 clk_out", e, clk_out, (e >= 454) ? 1'b1 : 1'b0);
      chk("R6 rst_n", e, rst_n_out, (e >= 517) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_powerdown();
    set_hold(1'b0);
    for (int e = 1; e <= 12; e++) begin
      tick();
      chk("R7 rst_n on fall", e, rst_n_out, (e < 5) ? 1'b1 : 1'b0);
      chk("R8 rails drop", e, rail_en, (e < 8) ? 6'h3F : 6'h00);
      chk("R8 clk_out stop", e, clk_out, (e <= 8) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_abort();
    set_hold(1'b1);
    repeat (200) tick();
    chk("R9 partial bring-up", 200, rail_en, 6'h07);
    set_hold(1'b0);
    for (int e = 1; e <= 120; e++) begin
      tick();
      chk("R9 abort rails", e, rail_en, (e < 8) ? 6'h07 : 6'h00);
      chk("R9 abort rst_n", e, rst_n_out, 1'b0);
      chk("R9 abort clk_out", e, clk_out, 1'b0);
      chk("R11 thermometer", e, ((rail_en + 6'h01) & rail_en), 6'h00);
    end
  endtask

  task automatic t_reenter();
    set_hold(1'b1);
    repeat (530) tick();
    chk("R10 fully on before test", 0, rst_n_out, 1'b1);
    set_hold(1'b0);
    for (int e = 1; e <= 3; e++) begin
      tick();
      chk("R10 rails early", e, rail_en, 6'h3F);
      chk("R10 rst_n early", e, rst_n_out, 1'b1);
    end
    set_hold(1'b1);
    for (int e = 4; e <= 140; e++) begin
      tick();
      chk("R10 rst_n", e, rst_n_out, (e < 5) ? 1'b1 : 1'b0);
      if (e < 8)       chk("R10 rails before cut", e, rail_en, 6'h3F);
      else if (e < 75) chk("R10 no early restart", e, rail_en, 6'h00);
      else             chk("R10 restart order", e, rail_en, rails_from(e, 75));
    end
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_powerdown();
    t_abort();
    t_reenter();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule